// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates the virtual address of a user-mode word access into a physical address by walking a page table that lives in word-addressed memory. A run-time configuration word packs two shift widths: the level-one shift and the page-offset shift. When the two shifts differ, the walk goes through two levels. When they are equal, the first-level entry is already the final entry. A request is accepted with a one-cycle start pulse. The walker then fetches table entries over a simple synchronous memory port and writes the accessed and modified flags back into the final entry. It ends with either a done pulse or a fault pulse that carries a cause code.

Supervisor accesses, and any access made while translation is switched off, pass straight through untranslated. Every result, translated or not, is then checked against the top of memory and against an I/O window. Misaligned addresses are rejected before any memory traffic takes place. A fault caused by a missing page also records the page-aligned virtual address, so that a handler can fill in the entry and retry the access.

Top module: `pt_walker`

## Requirements
- R1: A virtual address whose two low bits are not both zero ends in a fault with cause code 1 (alignment). No memory request is issued for it.
- R2: When the user flag is low or the translation-enable flag is low, the physical address equals the virtual address, and no table memory is accessed.
- R3: The shift word carries the level-one shift in bits 15:0 and the page (offset) shift in bits 31:16. The page mask is (1 << page shift) - 1.
- R4: The level-one index is (virtual address with its offset bits cleared) >> level-one shift. An index greater than or equal to the size input ends in a fault with cause code 2 (access), and no memory is accessed.
- R5: Each entry is read at the byte address base + 4 * index. For level one the base is the table base input. For level two the base is the level-one entry.
- R6: When the two shifts are equal, exactly one entry read occurs, and that entry is the final entry.
- R7: When the shifts differ, a zero level-one entry ends in a fault with cause code 3 (page). Otherwise the level-two index is (virtual address >> page shift) masked to (level-one shift - page shift) bits.
- R8: A final entry with bit 0 (valid) clear ends in a fault with cause code 3. The faulting-address output then takes the virtual address with its offset bits cleared. Other results leave that output unchanged.
- R9: A valid final entry is written back once, at its own address, with bit 1 (referenced) set. On a write access bit 2 (dirty) is also set. All other bits are unchanged.
- R10: The physical address is the final entry with bits 2:0 and the offset bits cleared, ORed with the offset bits of the virtual address.
- R11: A physical address is accepted when it is at most MEM_LIMIT, or when it lies between IO_BASE and IO_BASE + IO_SPAN inclusive. Any other address ends in a fault with cause code 2, after the write-back.
- R12: Each request ends in exactly one one-cycle pulse on either done or fault, never both. The physical address and cause are held until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted while idle |
| vaddr_i | input | 32 | Virtual byte address |
| write_i | input | 1 | Access is a write |
| user_i | input | 1 | Access is made in user mode |
| xlate_en_i | input | 1 | Translation enabled |
| cfg_base_i | input | 32 | Level-one table base (byte address) |
| cfg_shift_i | input | 32 | Packed shifts: level-one in 15:0, page in 31:16 |
| cfg_l1_size_i | input | 32 | Number of level-one entries |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read request |
| done_o | output | 1 | Successful translation pulse |
| fault_o | output | 1 | Fault pulse |
| fault_cause_o | output | 2 | 0 none, 1 alignment, 2 access, 3 page |
| paddr_o | output | 32 | Translated physical address |
| fault_vaddr_o | output | 32 | Page-aligned address of the last missing-page fault |

## Verification
The bench builds the walker with MEM_LIMIT = 0x40000, IO_BASE = 0x80000000 and IO_SPAN = 0xFFFF. With these values, random frame numbers in the entries land on both sides of the memory limit, and some land inside the I/O window. This makes the range check reachable in both directions, including the exact limit address and the address one word past it. The bench runs the two-level layout (shifts 19 and 13) and the one-level layout (both shifts 13) against small tables in a 4 KB memory model. Those tables contain zero level-one entries, invalid final entries and junk low bits, and the level-one index is driven past the size boundary.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int FLAG_VALID = 0;
  localparam int FLAG_REF   = 1;
  localparam int FLAG_DIRTY = 2;
  localparam int FLAG_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_FETCH_L1, ST_FETCH_L2, ST_WRITEBACK, ST_FINISH
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE, CAUSE_ALIGN, CAUSE_ACCESS, CAUSE_PAGE
  } fault_cause_e;
endpackage

// File: rtl/ptw_decode.sv
module ptw_decode #(
  parameter int AW  = 32,
  parameter int SHW = 16
) (
  input  logic [AW-1:0]    va,
  input  logic [2*SHW-1:0] shifts,
  output logic [AW-1:0]    page_mask,
  output logic [AW-1:0]    l1_idx,
  output logic [AW-1:0]    l2_idx,
  output logic             two_level
);
  localparam int SA_W = $clog2(AW);

  logic [SHW-1:0]  l1_field, pg_field;
  logic [SA_W-1:0] l1_sh, pg_sh, l2_bits;

  assign l1_field  = shifts[SHW-1:0];
  assign pg_field  = shifts[2*SHW-1:SHW];
  assign l1_sh     = l1_field[SA_W-1:0];
  assign pg_sh     = pg_field[SA_W-1:0];
  assign l2_bits   = l1_sh - pg_sh;
  assign two_level = (l1_field != pg_field);
  assign page_mask = ~({AW{1'b1}} << pg_sh);
  assign l1_idx    = (va & ~page_mask) >> l1_sh;
  assign l2_idx    = (va >> pg_sh) & ~({AW{1'b1}} << l2_bits);
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
  import ptw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ent,
  input  logic [AW-1:0] page_mask,
  input  logic [AW-1:0] va,
  input  logic          wr,
  output logic          valid,
  output logic [AW-1:0] pa,
  output logic [AW-1:0] wb_data
);
  localparam logic [AW-1:0] FLAG_MASK = (AW'(1) << FLAG_W) - AW'(1);
  localparam logic [AW-1:0] REF_BIT   = AW'(1) << FLAG_REF;
  localparam logic [AW-1:0] DIRTY_BIT = AW'(1) << FLAG_DIRTY;

  assign valid   = ent[FLAG_VALID];
  assign pa      = (ent & ~(page_mask | FLAG_MASK)) | (va & page_mask);
  assign wb_data = ent | REF_BIT | (wr ? DIRTY_BIT : '0);
endmodule

// File: rtl/ptw_bounds.sv
module ptw_bounds #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] MEM_LIMIT = 32'h0020_0000,
  parameter logic [AW-1:0] IO_BASE   = 32'hFFF0_0000,
  parameter logic [AW-1:0] IO_SPAN   = 32'h000F_FFFF
) (
  input  logic [AW-1:0] pa,
  output logic          ok
);
  localparam logic [AW-1:0] IO_TOP = IO_BASE + IO_SPAN;

  assign ok = (pa <= MEM_LIMIT) || ((pa >= IO_BASE) && (pa <= IO_TOP));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            SHW       = 16,
  parameter logic [AW-1:0] MEM_LIMIT = 32'h0020_0000,
  parameter logic [AW-1:0] IO_BASE   = 32'hFFF0_0000,
  parameter logic [AW-1:0] IO_SPAN   = 32'h000F_FFFF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [AW-1:0]  vaddr_i,
  input  logic           write_i,
  input  logic           user_i,
  input  logic           xlate_en_i,
  input  logic [AW-1:0]  cfg_base_i,
  input  logic [2*SHW-1:0] cfg_shift_i,
  input  logic [AW-1:0]  cfg_l1_size_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [AW-1:0]  mem_wdata_o,
  input  logic [AW-1:0]  mem_rdata_i,
  output logic           done_o,
  output logic           fault_o,
  output logic [1:0]     fault_cause_o,
  output logic [AW-1:0]  paddr_o,
  output logic [AW-1:0]  fault_vaddr_o
);
  walk_state_e  state;
  logic         phase;
  logic [AW-1:0] req_va;
  logic         req_wr, req_xl;
  logic [AW-1:0] pa_r, fva_r, addr_r, wdata_r;
  logic         req_r, we_r, done_r, fault_r;
  fault_cause_e cause_r;

  logic [AW-1:0] page_mask, l1_idx, l2_idx;
  logic          two_level;
  logic          leaf_valid;
  logic [AW-1:0] leaf_pa, leaf_wb;
  logic          pa_ok;

  ptw_decode #(.AW(AW), .SHW(SHW)) u_decode (
    .va(req_va), .shifts(cfg_shift_i), .page_mask(page_mask),
    .l1_idx(l1_idx), .l2_idx(l2_idx), .two_level(two_level)
  );

  ptw_leaf #(.AW(AW)) u_leaf (
    .ent(mem_rdata_i), .page_mask(page_mask), .va(req_va), .wr(req_wr),
    .valid(leaf_valid), .pa(leaf_pa), .wb_data(leaf_wb)
  );

  ptw_bounds #(.AW(AW), .MEM_LIMIT(MEM_LIMIT), .IO_BASE(IO_BASE), .IO_SPAN(IO_SPAN)) u_bounds (
    .pa(pa_r), .ok(pa_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      req_va  <= '0;
      req_wr  <= 1'b0;
      req_xl  <= 1'b0;
      pa_r    <= '0;
      fva_r   <= '0;
      addr_r  <= '0;
      wdata_r <= '0;
      req_r   <= 1'b0;
      we_r    <= 1'b0;
      done_r  <= 1'b0;
      fault_r <= 1'b0;
      cause_r <= CAUSE_NONE;
    end else begin
      done_r  <= 1'b0;
      fault_r <= 1'b0;
      req_r   <= 1'b0;
      we_r    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            req_va <= vaddr_i;
            req_wr <= write_i;
            req_xl <= user_i && xlate_en_i;
            state  <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (req_va[1:0] != 2'b00) begin
            fault_r <= 1'b1;
            cause_r <= CAUSE_ALIGN;
            state   <= ST_IDLE;
          end else if (!req_xl) begin
            pa_r  <= req_va;
            state <= ST_FINISH;
          end else if (l1_idx >= cfg_l1_size_i) begin
            fault_r <= 1'b1;
            cause_r <= CAUSE_ACCESS;
            state   <= ST_IDLE;
          end else begin
            req_r  <= 1'b1;
            addr_r <= cfg_base_i + (l1_idx << 2);
            phase  <= 1'b0;
            state  <= ST_FETCH_L1;
          end
        end
        ST_FETCH_L1, ST_FETCH_L2: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (state == ST_FETCH_L1 && two_level) begin
              if (mem_rdata_i == '0) begin
                fault_r <= 1'b1;
                cause_r <= CAUSE_PAGE;
                state   <= ST_IDLE;
              end else begin
                req_r  <= 1'b1;
                addr_r <= mem_rdata_i + (l2_idx << 2);
                state  <= ST_FETCH_L2;
              end
            end else if (!leaf_valid) begin
              fault_r <= 1'b1;
              cause_r <= CAUSE_PAGE;
              fva_r   <= req_va & ~page_mask;
              state   <= ST_IDLE;
            end else begin
              req_r   <= 1'b1;
              we_r    <= 1'b1;
              wdata_r <= leaf_wb;
              pa_r    <= leaf_pa;
              state   <= ST_WRITEBACK;
            end
          end
        end
        ST_WRITEBACK: state <= ST_FINISH;
        ST_FINISH: begin
          if (pa_ok) begin
            done_r  <= 1'b1;
            cause_r <= CAUSE_NONE;
          end else begin
            fault_r <= 1'b1;
            cause_r <= CAUSE_ACCESS;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o     = req_r;
  assign mem_we_o      = we_r;
  assign mem_addr_o    = addr_r;
  assign mem_wdata_o   = wdata_r;
  assign done_o        = done_r;
  assign fault_o       = fault_r;
  assign fault_cause_o = cause_r;
  assign paddr_o       = pa_r;
  assign fault_vaddr_o = fva_r;

  // R1: no table traffic for a misaligned request
  a_r1_no_fetch_misaligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (req_va[1:0] == 2'b00));

  // R2: untranslated results are the identity
  a_r2_bypass_identity: assert property (@(posedge clk) disable iff (rst)
    (done_o && !req_xl) |-> (paddr_o == req_va));

  // R2: bypass never touches memory
  a_r2_bypass_no_mem: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && state != ST_IDLE) |-> req_xl);

  // R6: second level only when the shifts differ
  a_r6_single_fetch: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH_L2) |-> two_level);

  // R9: write-back carries valid and referenced, and dirty on writes
  a_r9_wb_flags: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_wdata_o[FLAG_VALID] && mem_wdata_o[FLAG_REF]));

  a_r9_wb_dirty: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && req_wr) |-> mem_wdata_o[FLAG_DIRTY]);

  // R11: a completed translation is inside memory or the I/O window
  a_r11_range_ok: assert property (@(posedge clk) disable iff (rst)
    done_o |-> pa_ok);

  // R12: one-cycle, mutually exclusive result pulses
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, fault_o}));

  a_r12_pulse: assert property (@(posedge clk) disable iff (rst)
    (done_o || fault_o) |=> !(done_o || fault_o));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam logic [31:0] MEML = 32'h0004_0000;
  localparam logic [31:0] IOB  = 32'h8000_0000;
  localparam logic [31:0] IOS  = 32'h0000_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, wr = 1'b0, usr = 1'b0, xen = 1'b0;
  logic [31:0] va = '0, cbase = '0, cshift = '0, csize = '0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic done, fault;
  logic [1:0] cause;
  logic [31:0] paddr, fva;

  always #2.5 clk = ~clk;

  pt_walker #(.MEM_LIMIT(MEML), .IO_BASE(IOB), .IO_SPAN(IOS)) dut (
    .clk(clk), .rst(rst), .start_i(start), .vaddr_i(va), .write_i(wr),
    .user_i(usr), .xlate_en_i(xen), .cfg_base_i(cbase), .cfg_shift_i(cshift),
    .cfg_l1_size_i(csize), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .fault_cause_o(cause), .paddr_o(paddr),
    .fault_vaddr_o(fva)
  );

  logic [31:0] mem [0:1023];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_hist [0:3];
  logic [31:0] last_waddr = '0, last_wdata = '0;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        last_waddr <= mem_addr;
        last_wdata <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_hist[rd_cnt % 4] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
      mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // expected-value state
  int e_kind, e_reads, e_writes;
  logic [31:0] e_pa, e_fva = '0, e_waddr, e_wdata, e_rd0, e_rd1;

  task automatic model(input logic [31:0] v, input bit w, input bit xl);
    logic [31:0] l1s, ps, mask, idx, a1, a2, e, pte;
    e_kind = 0; e_reads = 0; e_writes = 0; e_pa = '0;
    if (v[1:0] != 2'b00) begin
      e_kind = 1;
      return;
    end
    if (!xl) begin
      e_pa = v;
    end else begin
      l1s  = {16'd0, cshift[15:0]};
      ps   = {16'd0, cshift[31:16]};
      mask = (32'd1 << ps) - 32'd1;
      idx  = (v & ~mask) >> l1s;
      if (idx >= csize) begin
        e_kind = 2;
        return;
      end
      a1 = cbase + 4 * idx;
      e_reads = 1; e_rd0 = a1; e = mem[a1[11:2]]; pte = a1;
      if (l1s != ps) begin
        if (e == 0) begin
          e_kind = 3;
          return;
        end
        a2 = e + 4 * ((v >> ps) & ((32'd1 << (l1s - ps)) - 32'd1));
        e_reads = 2; e_rd1 = a2; pte = a2; e = mem[a2[11:2]];
      end
      if (!e[0]) begin
        e_kind = 3;
        e_fva = v & ~mask;
        return;
      end
      e_writes = 1; e_waddr = pte;
      e_wdata = e | 32'h2 | (w ? 32'h4 : 32'h0);
      e_pa = (e & ~(mask | 32'h7)) | (v & mask);
    end
    if (!((e_pa <= MEML) || (e_pa >= IOB && e_pa <= IOB + IOS))) e_kind = 2;
  endtask

  task automatic run(input logic [31:0] v, input bit w, input bit u, input bit en, input string tag);
    int r0, w0, akind, to;
    bit got;
    model(v, w, u && en);
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    va = v; wr = w; usr = u; xen = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; to = 0; akind = 7;
    while (!got && to < 40) begin
      @(negedge clk);
      to++;
      if (done) begin akind = 0; got = 1; end
      else if (fault) begin akind = int'(cause); got = 1; end
    end
    chk(akind == e_kind, tag, akind, e_kind);
    if (e_kind == 0) chk(paddr == e_pa, "R10", paddr, e_pa);
    chk((wr_cnt - w0) == e_writes, "R9", wr_cnt - w0, e_writes);
    if (e_writes == 1) begin
      chk(last_waddr == e_waddr, "R9", last_waddr, e_waddr);
      chk(last_wdata == e_wdata, "R9", last_wdata, e_wdata);
    end
    chk((rd_cnt - r0) == e_reads, "R6", rd_cnt - r0, e_reads);
    if (e_reads >= 1) chk(rd_hist[r0 % 4] == e_rd0, "R5", rd_hist[r0 % 4], e_rd0);
    if (e_reads == 2) chk(rd_hist[(r0 + 1) % 4] == e_rd1, "R7", rd_hist[(r0 + 1) % 4], e_rd1);
    chk(fva == e_fva, "R8", fva, e_fva);
    @(negedge clk);
    chk(!done && !fault, "R12", {30'd0, done, fault}, 32'd0);
  endtask

  function automatic logic [31:0] rnd_leaf();
    logic [31:0] e;
    if ($urandom % 10 == 0) e = IOB | ($urandom & 32'h0000_E000);
    else e = $urandom & 32'h0007_E000;
    e |= $urandom & 32'h0000_1FF8;
    e |= $urandom & 32'h6;
    if ($urandom % 4 != 0) e |= 32'h1;
    return e;
  endfunction

  task automatic build(input bit two);
    for (int i = 0; i < 1024; i++) mem[i] = rnd_leaf();
    cbase = 32'h0;
    if (two) begin
      cshift = {16'd13, 16'd19};
      csize  = 32'd40;
      for (int i = 0; i < 40; i++)
        mem[i] = (i % 7 == 3) ? 32'h0 : 32'h400 + 32'h100 * (i % 12);
    end else begin
      cshift = {16'd13, 16'd13};
      csize  = 32'd64;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) rd_hist[i] = '0;
    build(1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !fault, "R12", {30'd0, done, fault}, 0);
    chk(!mem_req, "R12", {31'd0, mem_req}, 0);
    chk(paddr == 0, "R12", paddr, 0);
    chk(fva == 0, "R8", fva, 0);

    // directed, two-level layout
    mem[32'h400 >> 2] = MEML | 32'h1;
    mem[(32'h400 >> 2) + 1] = 32'h0000_2000;
    mem[(32'h400 >> 2) + 2] = 32'h0001_A000 | 32'h1FF8 | 32'h1;
    mem[(32'h400 >> 2) + 3] = 32'h8000_4000 | 32'h1;
    mem[39] = 32'h500;
    mem[32'h500 >> 2] = 32'h0000_2000 | 32'h1;
    run(32'h0000_0002, 0, 1, 1, "R1");
    run(32'h0000_0001, 1, 0, 0, "R1");
    run(32'h0000_1234 & ~32'h3, 0, 0, 1, "R2");
    run(32'h8000_0010, 1, 1, 0, "R2");
    run(32'h0005_0000, 0, 0, 0, "R11");
    run(32'h0000_0000, 0, 1, 1, "R11");
    run(32'h0000_0004, 0, 1, 1, "R11");
    run(32'h0000_2010, 0, 1, 1, "R8");
    run(32'h0000_4124, 1, 1, 1, "R10");
    run(32'h0000_6008, 0, 1, 1, "R11");
    run(32'd3 << 19, 0, 1, 1, "R7");
    run(32'd40 << 19, 0, 1, 1, "R4");
    run(32'd39 << 19, 1, 1, 1, "R4");

    for (int n = 0; n < 150; n++) begin
      logic [31:0] v;
      v = (($urandom % 42) << 19) | ($urandom & 32'h7FFFC);
      if ($urandom % 20 == 0) v |= 32'h1 + ($urandom % 3);
      if ($urandom % 8 == 0) run($urandom & 32'h0007_FFFC, $urandom % 2, 0, 1, "R2");
      else run(v, $urandom % 2, 1, 1, "R3");
    end

    build(1'b0);
    mem[5] = 32'h0000_6000 | 32'h1;
    run((32'd5 << 13) | 32'h20, 0, 1, 1, "R6");
    run(32'd64 << 13, 0, 1, 1, "R4");
    for (int n = 0; n < 150; n++) begin
      logic [31:0] v;
      v = (($urandom % 66) << 13) | ($urandom & 32'h1FFC);
      if ($urandom % 20 == 0) v |= 32'h2;
      run(v, $urandom % 2, 1, ($urandom % 10 != 0), "R3");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog R12 actual=0x%08h expected=0x%08h", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule